// File: doc/BRIEF.md
# In-Order Issue Gate

This block sits between a decode stage and the execution units of a simple in-order pipeline. Each cycle it sees one candidate instruction: a valid flag, a flag that marks the instruction as one that must go through the pipeline on its own, the register numbers it reads and writes, and whether it reads or writes the condition register. It drives issueValid in the same cycle when the instruction may go ahead. When it must hold the instruction back, it raises stall instead. The decode stage keeps presenting a stalled instruction until it is issued or flushed.

The gate keeps an in-order record of the instructions in flight, up to PIPE_DEPTH of them. Each issue adds a record and each completion pulse retires the oldest one. A completion in the current cycle is applied before the cycle's decision is made. Single-pipe instructions are serialized by a three-state sequencer: idle, draining older work, and waiting for the lone instruction. An ordinary instruction is held while one of its sources, or its condition-register read, depends on an in-flight producer. A flush discards the candidate and forgets all pending producers. The stopped output tells a debug controller that a stop-marked instruction has reached the gate with nothing left in flight.

Top module: `issue_gate`

## Requirements
- R1: While rst is high, issueValid and stall stay low. Once the reset has taken effect, the in-flight count is zero and the sequencer is idle, so stopped equals stopMark.
- R2: Suppose a valid, non-flushed, ordinary (sglPipe=0) instruction arrives while the sequencer is idle and it has no hazard. Suppose also that fewer than PIPE_DEPTH instructions stay in flight once this cycle's completion is applied. Then issueValid is high in that same cycle.
- R3: An ordinary instruction is not issued while a valid source, srcReg[k*5 +: 5] with srcValid[k] set, equals the destination of an instruction still in flight that was issued with dstValid set.
- R4: An ordinary instruction with crRead set is not issued while an in-flight instruction was issued with crWrite set.
- R5: A completion pulse retires the oldest in-flight instruction within the same cycle, so a hazard caused only by that instruction no longer blocks issue in that cycle.
- R6: A single-pipe instruction that arrives with nothing in flight is issued at once. After that, no instruction is issued until the in-flight count, after the current cycle's completion, is zero. In the cycle it becomes zero the gate again behaves as idle.
- R7: A single-pipe instruction that arrives while work is in flight is stalled and not issued. It is issued in the first cycle in which the in-flight count, after that cycle's completion, is zero.
- R8: While flush is high, issueValid is low and the in-flight count does not grow. All pending producer records are forgotten for hazard purposes, and a wait for older work is abandoned.
- R9: stopped is high exactly when stopMark is high and the in-flight count, after the current cycle's completion, is zero. The count rises by one for each issue and falls by one for each completion pulse while it is nonzero, and both can occur in one cycle.
- R10: An ordinary instruction is stalled when PIPE_DEPTH instructions would remain in flight after the current cycle's completion.
- R11: stall is high exactly when inValid is high, flush is low, rst is low and issueValid is low.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | A candidate instruction is present |
| sglPipe | input | 1 | Candidate must pass through the pipeline alone |
| flush | input | 1 | Discard candidate and forget pending producers |
| complete | input | 1 | Oldest in-flight instruction finished |
| stopMark | input | 1 | Candidate carries a debug stop request |
| dstValid | input | 1 | Candidate writes a register |
| dstReg | input | 5 | Destination register number |
| srcValid | input | 3 | Per-source read enables |
| srcReg | input | 15 | Source register numbers, source k at bits k*5 +: 5 |
| crRead | input | 1 | Candidate reads the condition register |
| crWrite | input | 1 | Candidate writes the condition register |
| issueValid | output | 1 | Candidate is issued this cycle |
| stall | output | 1 | Candidate is held this cycle |
| stopped | output | 1 | Stop mark seen with the pipeline empty |

## Verification
The checks assume that complete pulses only while at least one instruction is in flight. They also assume that a stalled candidate is held unchanged until it is issued or flushed, and that complete is low during reset. The stimulus tracks the in-flight count in a bench model and only draws a completion when that count is nonzero. It re-presents the same instruction after every stall and draws a fresh one only after an issue, an empty slot or a flush. Register numbers are drawn from a small range so that source hazards arise often. Single-pipe instructions and flushes are drawn rarely so that they land in the middle of ordinary traffic.

// File: rtl/issue_gate_pkg.sv
package issue_gate_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WAIT_PREV = 2'd1,
    ST_WAIT_CUR  = 2'd2
  } serState_t;

  // strobes from the sequencer to the in-flight tracker
  typedef struct packed {
    logic push;
    logic clearTags;
  } trackCmd_t;

  // status from the tracker back to the sequencer
  typedef struct packed {
    logic hazard;
    logic drained;
    logic full;
  } trackStat_t;

endpackage

// File: rtl/issue_gate_track.sv
module issue_gate_track
  import issue_gate_pkg::*;
#(
  parameter int PIPE_DEPTH = 2,
  parameter int REG_BITS   = 5,
  parameter int NUM_SRC    = 3,
  parameter int CNT_W      = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        complete,
  input  trackCmd_t                   cmd,
  input  logic                        dstValid,
  input  logic [REG_BITS-1:0]         dstReg,
  input  logic [NUM_SRC-1:0]          srcValid,
  input  logic [NUM_SRC*REG_BITS-1:0] srcReg,
  input  logic                        crRead,
  input  logic                        crWrite,
  output trackStat_t                  stat,
  output logic [CNT_W-1:0]            inflightCnt
);

  logic [CNT_W-1:0]    cnt;
  logic [CNT_W-1:0]    effCnt;
  logic                popNow;

  logic                tagDv  [PIPE_DEPTH];
  logic [REG_BITS-1:0] tagDst [PIPE_DEPTH];
  logic                tagCw  [PIPE_DEPTH];

  logic                shDv   [PIPE_DEPTH];
  logic [REG_BITS-1:0] shDst  [PIPE_DEPTH];
  logic                shCw   [PIPE_DEPTH];

  logic [PIPE_DEPTH-1:0] liveEnt;
  logic [PIPE_DEPTH-1:0] entHit;

  // retire the oldest record first, so this cycle's decision sees it gone
  always_comb begin
    popNow = complete && (cnt != '0);
    effCnt = cnt - CNT_W'(popNow);
    for (int i = 0; i < PIPE_DEPTH; i++) begin
      int up;
      up = (i < PIPE_DEPTH - 1) ? i + 1 : i;
      if (!popNow) begin
        shDv[i]  = tagDv[i];
        shDst[i] = tagDst[i];
        shCw[i]  = tagCw[i];
      end else if (i < PIPE_DEPTH - 1) begin
        shDv[i]  = tagDv[up];
        shDst[i] = tagDst[up];
        shCw[i]  = tagCw[up];
      end else begin
        shDv[i]  = 1'b0;
        shDst[i] = '0;
        shCw[i]  = 1'b0;
      end
    end
  end

  for (genvar e = 0; e < PIPE_DEPTH; e++) begin : g_ent
    logic [NUM_SRC-1:0] srcHit;
    assign liveEnt[e] = (CNT_W'(e) < effCnt);
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign srcHit[s] = srcValid[s] &&
                         (srcReg[s*REG_BITS +: REG_BITS] == shDst[e]);
    end
    assign entHit[e] = liveEnt[e] &&
                       ((shDv[e] && (|srcHit)) || (shCw[e] && crRead));
  end

  assign stat.hazard  = |entHit;
  assign stat.drained = (effCnt == '0);
  assign stat.full    = (effCnt == CNT_W'(PIPE_DEPTH));
  assign inflightCnt  = cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      for (int i = 0; i < PIPE_DEPTH; i++) begin
        tagDv[i]  <= 1'b0;
        tagDst[i] <= '0;
        tagCw[i]  <= 1'b0;
      end
    end else begin
      cnt <= effCnt + CNT_W'(cmd.push);
      for (int i = 0; i < PIPE_DEPTH; i++) begin
        if (cmd.push && (CNT_W'(i) == effCnt)) begin
          tagDv[i]  <= dstValid;
          tagDst[i] <= dstReg;
          tagCw[i]  <= crWrite;
        end else begin
          tagDv[i]  <= shDv[i] && !cmd.clearTags;
          tagDst[i] <= shDst[i];
          tagCw[i]  <= shCw[i] && !cmd.clearTags;
        end
      end
    end
  end

endmodule

// File: rtl/issue_gate_seq.sv
module issue_gate_seq
  import issue_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic       sglPipe,
  input  logic       flush,
  input  trackStat_t stat,
  output logic       issueValid,
  output logic       stall,
  output trackCmd_t  cmd,
  output serState_t  state
);

  serState_t nxtState;
  logic      issueNow;
  logic      valOk;
  logic      idleLike;

  always_comb begin
    valOk    = inValid && !flush;
    idleLike = (state == ST_IDLE) || (state == ST_WAIT_CUR && stat.drained);
    nxtState = state;
    issueNow = 1'b0;
    if (idleLike) begin
      nxtState = ST_IDLE;
      if (valOk) begin
        if (sglPipe) begin
          if (stat.drained) begin
            issueNow = 1'b1;
            nxtState = ST_WAIT_CUR;
          end else begin
            nxtState = ST_WAIT_PREV;
          end
        end else begin
          issueNow = !stat.hazard && !stat.full;
        end
      end
    end else begin
      case (state)
        ST_WAIT_PREV: begin
          if (flush) begin
            nxtState = ST_IDLE;
          end else if (stat.drained) begin
            issueNow = inValid;
            nxtState = inValid ? ST_WAIT_CUR : ST_IDLE;
          end
        end
        ST_WAIT_CUR: begin
          nxtState = ST_WAIT_CUR;
        end
        default: begin
          nxtState = ST_IDLE;
        end
      endcase
    end
    if (rst) begin
      issueNow = 1'b0;
    end
  end

  assign issueValid    = issueNow;
  assign stall         = valOk && !issueNow && !rst;
  assign cmd.push      = issueNow;
  assign cmd.clearTags = flush;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      state <= nxtState;
    end
  end

endmodule

// File: rtl/issue_gate.sv
module issue_gate
  import issue_gate_pkg::*;
#(
  parameter int PIPE_DEPTH = 2,
  parameter int REG_BITS   = 5,
  parameter int NUM_SRC    = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        inValid,
  input  logic                        sglPipe,
  input  logic                        flush,
  input  logic                        complete,
  input  logic                        stopMark,
  input  logic                        dstValid,
  input  logic [REG_BITS-1:0]         dstReg,
  input  logic [NUM_SRC-1:0]          srcValid,
  input  logic [NUM_SRC*REG_BITS-1:0] srcReg,
  input  logic                        crRead,
  input  logic                        crWrite,
  output logic                        issueValid,
  output logic                        stall,
  output logic                        stopped
);

  localparam int CNT_W = $clog2(PIPE_DEPTH + 1);

  trackCmd_t        trkCmd;
  trackStat_t       trkStat;
  serState_t        serState;
  logic [CNT_W-1:0] inflightCnt;

  issue_gate_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .inValid    (inValid),
    .sglPipe    (sglPipe),
    .flush      (flush),
    .stat       (trkStat),
    .issueValid (issueValid),
    .stall      (stall),
    .cmd        (trkCmd),
    .state      (serState)
  );

  issue_gate_track #(
    .PIPE_DEPTH (PIPE_DEPTH),
    .REG_BITS   (REG_BITS),
    .NUM_SRC    (NUM_SRC),
    .CNT_W      (CNT_W)
  ) u_track (
    .clk         (clk),
    .rst         (rst),
    .complete    (complete),
    .cmd         (trkCmd),
    .dstValid    (dstValid),
    .dstReg      (dstReg),
    .srcValid    (srcValid),
    .srcReg      (srcReg),
    .crRead      (crRead),
    .crWrite     (crWrite),
    .stat        (trkStat),
    .inflightCnt (inflightCnt)
  );

  assign stopped = stopMark && trkStat.drained;

endmodule

// File: rtl/issue_gate_chk.sv
module issue_gate_chk
  import issue_gate_pkg::*;
#(
  parameter int PIPE_DEPTH = 2,
  parameter int CNT_W      = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             sglPipe,
  input logic             flush,
  input logic             complete,
  input logic             issueValid,
  input logic             stall,
  input serState_t        state,
  input trackStat_t       stat,
  input logic [CNT_W-1:0] cnt
);

  AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    flush |-> !issueValid);                                          // R8

  AST_STALL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    stall |-> (inValid && !issueValid));                             // R11

  AST_NO_HAZARD_ISSUE: assert property (@(posedge clk) disable iff (rst)
    issueValid |-> !stat.hazard);                                    // R3

  AST_SGL_ON_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (issueValid && sglPipe) |-> stat.drained);                       // R7

  AST_WAIT_CUR_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_CUR && !stat.drained) |-> !issueValid);        // R6

  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) <= PIPE_DEPTH);                                        // R10

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    inValid || !inValid |=> int'(cnt) == int'($past(cnt))
      - int'($past(complete && cnt != '0)) + int'($past(issueValid))); // R9

endmodule

bind issue_gate issue_gate_chk #(
  .PIPE_DEPTH (PIPE_DEPTH),
  .CNT_W      (CNT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .inValid    (inValid),
  .sglPipe    (sglPipe),
  .flush      (flush),
  .complete   (complete),
  .issueValid (issueValid),
  .stall      (stall),
  .state      (serState),
  .stat       (trkStat),
  .cnt        (inflightCnt)
);

// File: tb/issue_gate_tb.sv
`timescale 1ns/1ps
module issue_gate_tb;

  localparam int D  = 2;
  localparam int RB = 5;
  localparam int NS = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, inValid, sglPipe, flush, complete, stopMark;
  logic dstValid, crRead, crWrite;
  logic [RB-1:0] dstReg, s0, s1, s2;
  logic [NS-1:0] srcValid;
  logic issueValid, stall, stopped;

  issue_gate #(.PIPE_DEPTH(D), .REG_BITS(RB), .NUM_SRC(NS)) u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .sglPipe(sglPipe), .flush(flush),
    .complete(complete), .stopMark(stopMark), .dstValid(dstValid),
    .dstReg(dstReg), .srcValid(srcValid), .srcReg({s2, s1, s0}),
    .crRead(crRead), .crWrite(crWrite), .issueValid(issueValid),
    .stall(stall), .stopped(stopped)
  );

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  // reference model of the requirements
  int mCnt, mSt;
  int mDv[D], mDst[D], mCw[D];
  int nCnt, nSt;
  int nDv[D], nDst[D], nCw[D];
  bit lastIssue;

  task automatic chk(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit srcMatch(input int r);
    return (srcValid[0] && int'(s0) == r) || (srcValid[1] && int'(s1) == r) ||
           (srcValid[2] && int'(s2) == r);
  endfunction

  task automatic evalModel();
    bit pop, hs, hc, raw, valOk, drained, full, idleLike, iss;
    int eff;
    int sDv[D], sDst[D], sCw[D];
    string tag;
    pop = complete && mCnt > 0;
    eff = mCnt - (pop ? 1 : 0);
    for (int i = 0; i < D; i++) begin
      if (!pop) begin sDv[i] = mDv[i]; sDst[i] = mDst[i]; sCw[i] = mCw[i]; end
      else if (i < D - 1) begin sDv[i] = mDv[i+1]; sDst[i] = mDst[i+1]; sCw[i] = mCw[i+1]; end
      else begin sDv[i] = 0; sDst[i] = 0; sCw[i] = 0; end
    end
    hs = 0; hc = 0; raw = 0;
    for (int i = 0; i < eff; i++) begin
      if (sDv[i] != 0 && srcMatch(sDst[i])) hs = 1;
      if (sCw[i] != 0 && crRead) hc = 1;
    end
    for (int i = 0; i < mCnt; i++) begin
      if ((mDv[i] != 0 && srcMatch(mDst[i])) || (mCw[i] != 0 && crRead)) raw = 1;
    end
    valOk    = inValid && !flush;
    drained  = (eff == 0);
    full     = (eff == D);
    idleLike = (mSt == 0) || (mSt == 2 && drained);
    iss = 0; nSt = mSt; tag = "R2";
    if (idleLike) begin
      nSt = 0;
      if (valOk) begin
        if (sglPipe) begin
          if (drained) begin iss = 1; nSt = 2; tag = "R6"; end
          else begin nSt = 1; tag = "R7"; end
        end else begin
          iss = !hs && !hc && !full;
          tag = hs ? "R3" : hc ? "R4" : full ? "R10" : raw ? "R5" : "R2";
        end
      end else if (flush) tag = "R8";
    end else if (mSt == 1) begin
      tag = "R7";
      if (flush) begin nSt = 0; tag = "R8"; end
      else if (drained) begin iss = inValid; nSt = inValid ? 2 : 0; end
    end else begin
      tag = "R6";
    end
    chk(tag, issueValid, iss);
    chk("R11", stall, valOk && !iss);
    chk("R9", stopped, stopMark && drained);
    nCnt = eff + (iss ? 1 : 0);
    for (int i = 0; i < D; i++) begin
      if (iss && i == eff) begin
        nDv[i] = dstValid ? 1 : 0; nDst[i] = int'(dstReg); nCw[i] = crWrite ? 1 : 0;
      end else begin
        nDv[i] = flush ? 0 : sDv[i]; nDst[i] = sDst[i]; nCw[i] = flush ? 0 : sCw[i];
      end
    end
    lastIssue = iss;
  endtask

  // inputs are set at a falling edge before this is called
  task automatic cyc();
    #1;
    evalModel();
    @(posedge clk);
    mCnt = nCnt; mSt = nSt;
    for (int i = 0; i < D; i++) begin mDv[i] = nDv[i]; mDst[i] = nDst[i]; mCw[i] = nCw[i]; end
    @(negedge clk);
  endtask

  task automatic setIns(input logic v, input logic sg, input logic dv, input int d,
                        input logic [2:0] sv, input int a, input int b, input int c,
                        input logic cr, input logic cw);
    inValid = v; sglPipe = sg; dstValid = dv; dstReg = RB'(d); srcValid = sv;
    s0 = RB'(a); s1 = RB'(b); s2 = RB'(c); crRead = cr; crWrite = cw;
  endtask

  task automatic ctl(input logic fl, input logic cp, input logic sm);
    flush = fl; complete = cp; stopMark = sm;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    bit held;
    void'($urandom(32'd20240611));
    mCnt = 0; mSt = 0;
    for (int i = 0; i < D; i++) begin mDv[i] = 0; mDst[i] = 0; mCw[i] = 0; end
    rst = 1'b1;
    setIns(1, 0, 1, 1, 3'b000, 0, 0, 0, 0, 0);
    ctl(0, 0, 1);
    repeat (3) @(negedge clk);
    #1;
    chk("R1", issueValid, 1'b0);
    chk("R1", stall, 1'b0);
    chk("R1", stopped, 1'b1);
    @(negedge clk);
    rst = 1'b0;
    setIns(0, 0, 0, 0, 3'b000, 0, 0, 0, 0, 0);
    ctl(0, 0, 0);

    // source hazard, then cleared by same-cycle completion
    setIns(1, 0, 1, 3, 3'b000, 0, 0, 0, 0, 0); cyc();
    setIns(1, 0, 0, 0, 3'b001, 3, 0, 0, 0, 0); cyc(); cyc();
    ctl(0, 1, 0); cyc();
    setIns(0, 0, 0, 0, 3'b000, 0, 0, 0, 0, 0); cyc();
    ctl(0, 0, 0);
    // condition-register hazard
    setIns(1, 0, 0, 0, 3'b000, 0, 0, 0, 0, 1); cyc();
    setIns(1, 0, 0, 0, 3'b000, 0, 0, 0, 1, 0); cyc();
    ctl(0, 1, 0); cyc();
    setIns(0, 0, 0, 0, 3'b000, 0, 0, 0, 0, 0); cyc();
    ctl(0, 0, 0);
    // depth limit
    setIns(1, 0, 1, 5, 3'b000, 0, 0, 0, 0, 0); cyc();
    setIns(1, 0, 1, 6, 3'b000, 0, 0, 0, 0, 0); cyc();
    setIns(1, 0, 1, 7, 3'b010, 0, 9, 0, 0, 0); cyc();
    ctl(0, 1, 0); cyc();
    setIns(0, 0, 0, 0, 3'b000, 0, 0, 0, 0, 0); cyc(); cyc();
    ctl(0, 0, 0);
    // single-pipe behind older work, then blocking younger work
    setIns(1, 0, 1, 8, 3'b000, 0, 0, 0, 0, 0); cyc();
    setIns(1, 1, 0, 0, 3'b000, 0, 0, 0, 0, 0); cyc(); cyc();
    ctl(0, 1, 0); cyc();
    ctl(0, 0, 0);
    setIns(1, 0, 1, 9, 3'b000, 0, 0, 0, 0, 0); cyc(); cyc();
    ctl(0, 1, 0); cyc();
    setIns(0, 0, 0, 0, 3'b000, 0, 0, 0, 0, 0); cyc();
    ctl(0, 0, 0);
    // flush drops candidate and pending producer records
    setIns(1, 0, 1, 4, 3'b000, 0, 0, 0, 0, 1); cyc();
    setIns(1, 0, 0, 0, 3'b100, 0, 0, 4, 1, 0); ctl(1, 0, 0); cyc();
    ctl(0, 0, 0); cyc();
    // stop mark with work in flight, then drained
    setIns(0, 0, 0, 0, 3'b000, 0, 0, 0, 0, 0); ctl(0, 0, 1); cyc();
    ctl(0, 1, 1); cyc();
    ctl(0, 1, 1); cyc();
    ctl(0, 0, 0); cyc();

    // constrained random traffic, stalled candidates are held
    held = 0;
    for (int n = 0; n < 6000; n++) begin
      if (!held) begin
        setIns($urandom_range(0, 99) < 80, $urandom_range(0, 99) < 8,
               $urandom_range(0, 99) < 70, int'($urandom_range(0, 7)),
               3'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
               int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
               $urandom_range(0, 99) < 20, $urandom_range(0, 99) < 20);
      end
      ctl($urandom_range(0, 99) < 3,
          (mCnt > 0) && ($urandom_range(0, 99) < 40),
          $urandom_range(0, 99) < 10);
      held = inValid && !flush && !lastIssue;
      cyc();
      held = inValid && !flush && !lastIssue;
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule